// File: doc/BRIEF.md
# Fixed-Point Requantization Cast Unit

This block converts a fixed-point word from one format to another. The input format is set by a total width, a count of fraction bits and a signedness flag. The output format is set the same way, and may be wider or narrower on either side of the binary point. When fraction bits are dropped, a compile-time quantization mode picks the result: plain truncation, rounding to nearest with ties away from zero, or rounding to nearest with ties to an even last bit. When the result does not fit the output range, a compile-time overflow mode either clamps it to the nearest end of the range or keeps only the low output bits. In both overflow modes an overflow flag travels with the data.

The result can be delayed through a configurable number of register stages placed after the arithmetic. With zero stages the block is purely combinational. The stages have an active-low asynchronous reset, a synchronous clear and a clock enable, and the clear takes priority over the enable. A typical use is between arithmetic stages of a datapath, where a wide product or sum has to be brought back to a storage format.

Top module: `fxq_cast`

## Requirements
- R1: In truncate mode (`Q_TRUNC`), the fraction bits below the output LSB are dropped, which rounds toward minus infinity (input 5.9375 gives 5 in an integer output).
- R2: In symmetric mode (`Q_SYM`), the result is the nearest output value, and an exact tie goes to the neighbour of larger magnitude (1.375 gives 1.5 and -1.375 gives -1.5 at 2 fraction bits; -1.0625 gives -1.0).
- R3: In saturate mode (`O_SAT`), a value above the output range gives the largest code, and a value below it gives the most negative code (all zeros for an unsigned output).
- R4: In convergent mode (`Q_CONV`), the result is the nearest output value, and an exact tie goes to the neighbour whose LSB is 0 (1.375 gives 1.5, 1.625 gives 1.5, 1.875 gives 2.0 and -1.375 gives -1.5 at 2 fraction bits).
- R5: In wrap mode (`O_WRAP`), the output is the low OUT_W bits of the two's complement result, and all higher bits are discarded.
- R6: Rounding is done before the range check, so a round-up that carries past the largest code is then saturated or wrapped.
- R7: When the output has more fraction bits than the input, the value is shifted left with zero fill and without rounding. The value is sign-extended into a wider integer part.
- R8: While `srst_i` is high at a rising clock edge, every delay stage is loaded with zero (data and flag), whatever the value of `en_i`.
- R9: While `en_i` is low and `srst_i` is low, every delay stage keeps its value.
- R10: `ovf_o` is 1 exactly when the rounded value lay outside the output range, in both overflow modes. It is delayed together with its data word.
- R11: The output follows the input after exactly LATENCY enabled clock edges. With LATENCY=0 the output is a combinational function of the input.
- R12: With an unsigned output, a negative value saturates to 0 and raises `ovf_o`.
- R13: While `rst_ni` is low, all delay stages are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear of the delay stages, has priority over the enable |
| en_i | input | 1 | Clock enable of the delay stages |
| din_i | input | IN_W | Input word in the input format |
| dout_o | output | OUT_W | Converted word in the output format |
| ovf_o | output | 1 | Overflow flag, aligned with dout_o |

## Verification
The bench drives exact ties through both rounding modes, with positive and negative signs, and checks them against an odd and an even neighbour. A design that rounds ties in only one direction, or that treats negative ties like positive ones, gives a code that is off by one LSB. Round-ups that carry past the largest code must saturate in one instance and wrap to the most negative code in another, in both cases with the flag set. A design that checks the range before rounding lets these values through unflagged. The bench also checks negative values into an unsigned output and the sign extension when the output is widened. It checks the exact cycle in which each pipeline delivers its result, and it checks that the synchronous clear wins over a low enable.

// File: rtl/fxq_pkg.sv
`timescale 1ns/1ps
package fxq_pkg;
  typedef enum logic [1:0] {Q_TRUNC, Q_SYM, Q_CONV} qmode_e;
  typedef enum logic {O_WRAP, O_SAT} omode_e;
endpackage

// File: rtl/fxq_round.sv
`timescale 1ns/1ps
module fxq_round #(
  parameter int             IN_W      = 8,
  parameter int             IN_F      = 4,
  parameter bit             IN_SIGNED = 1'b1,
  parameter int             OUT_F     = 2,
  parameter int             WW        = 12,
  parameter fxq_pkg::qmode_e QMODE    = fxq_pkg::Q_SYM
) (
  input  logic [IN_W-1:0]        din_i,
  output logic signed [WW-1:0]   val_o
);
  localparam int SH = IN_F - OUT_F;

  logic                 sgn;
  logic signed [WW-1:0] ext;

  assign sgn = IN_SIGNED && din_i[IN_W-1];
  assign ext = {{(WW-IN_W){sgn}}, din_i};

  if (SH > 0) begin : g_narrow
    logic signed [WW-1:0] flr;
    logic half, rest_nz, neg, inc;

    assign flr  = ext >>> SH;
    assign half = ext[SH-1];
    assign neg  = ext[WW-1];
    if (SH > 1) begin : g_rest
      assign rest_nz = |ext[SH-2:0];
    end else begin : g_norest
      assign rest_nz = 1'b0;
    end

    always_comb begin
      inc = 1'b0;
      if (QMODE == fxq_pkg::Q_SYM)       inc = half & (rest_nz | ~neg);
      else if (QMODE == fxq_pkg::Q_CONV) inc = half & (rest_nz | flr[0]);
    end

    assign val_o = flr + {{(WW-1){1'b0}}, inc};
  end else begin : g_widen
    // zero fill on the right, sign already extended on the left
    assign val_o = ext <<< (OUT_F - IN_F);
  end
endmodule

// File: rtl/fxq_clamp.sv
`timescale 1ns/1ps
module fxq_clamp #(
  parameter int              WW         = 12,
  parameter int              OUT_W      = 5,
  parameter bit              OUT_SIGNED = 1'b1,
  parameter fxq_pkg::omode_e OMODE      = fxq_pkg::O_SAT
) (
  input  logic signed [WW-1:0] val_i,
  output logic [OUT_W-1:0]     data_o,
  output logic                 ovf_o
);
  localparam logic signed [WW-1:0] ONE = WW'(1);
  localparam logic signed [WW-1:0] HI  = OUT_SIGNED ? (ONE <<< (OUT_W-1)) - ONE
                                                    : (ONE <<< OUT_W) - ONE;
  localparam logic signed [WW-1:0] LO  = OUT_SIGNED ? -(ONE <<< (OUT_W-1)) : '0;

  logic above, below;

  assign above = val_i > HI;
  assign below = val_i < LO;
  assign ovf_o = above | below;

  if (OMODE == fxq_pkg::O_SAT) begin : g_sat
    always_comb begin
      if (above)      data_o = HI[OUT_W-1:0];
      else if (below) data_o = LO[OUT_W-1:0];
      else            data_o = val_i[OUT_W-1:0];
    end
  end else begin : g_wrap
    assign data_o = val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/fxq_delay.sv
`timescale 1ns/1ps
module fxq_delay #(
  parameter int W     = 6,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_comb
    assign q_o = d_i;
  end else begin : g_pipe
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      end else if (srst_i) begin
        for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
      end else if (en_i) begin
        stg[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      end
    end

    assign q_o = stg[DEPTH-1];
  end
endmodule

// File: rtl/fxq_cast.sv
`timescale 1ns/1ps
module fxq_cast #(
  parameter int              IN_W       = 8,
  parameter int              IN_F       = 4,
  parameter bit              IN_SIGNED  = 1'b1,
  parameter int              OUT_W      = 5,
  parameter int              OUT_F      = 2,
  parameter bit              OUT_SIGNED = 1'b1,
  parameter fxq_pkg::qmode_e QMODE      = fxq_pkg::Q_SYM,
  parameter fxq_pkg::omode_e OMODE      = fxq_pkg::O_SAT,
  parameter int              LATENCY    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             en_i,
  input  logic [IN_W-1:0]  din_i,
  output logic [OUT_W-1:0] dout_o,
  output logic             ovf_o
);
  localparam int LSH = (OUT_F > IN_F) ? OUT_F - IN_F : 0;
  localparam int WA  = IN_W + 2 + LSH;
  localparam int WB  = OUT_W + 2;
  localparam int WW  = (WA > WB) ? WA : WB;

  logic signed [WW-1:0] rnd_val;
  logic [OUT_W-1:0]     cl_data;
  logic                 cl_ovf;
  logic [OUT_W:0]       pipe_q;

  fxq_round #(
    .IN_W(IN_W), .IN_F(IN_F), .IN_SIGNED(IN_SIGNED),
    .OUT_F(OUT_F), .WW(WW), .QMODE(QMODE)
  ) u_round (
    .din_i(din_i),
    .val_o(rnd_val)
  );

  fxq_clamp #(
    .WW(WW), .OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED), .OMODE(OMODE)
  ) u_clamp (
    .val_i (rnd_val),
    .data_o(cl_data),
    .ovf_o (cl_ovf)
  );

  fxq_delay #(
    .W(OUT_W + 1), .DEPTH(LATENCY)
  ) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .srst_i(srst_i),
    .en_i  (en_i),
    .d_i   ({cl_ovf, cl_data}),
    .q_o   (pipe_q)
  );

  assign dout_o = pipe_q[OUT_W-1:0];
  assign ovf_o  = pipe_q[OUT_W];
endmodule

// File: rtl/fxq_cast_chk.sv
`timescale 1ns/1ps
module fxq_cast_chk #(
  parameter int              OUT_W      = 5,
  parameter bit              OUT_SIGNED = 1'b1,
  parameter fxq_pkg::omode_e OMODE      = fxq_pkg::O_SAT,
  parameter int              LATENCY    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             srst_i,
  input logic             en_i,
  input logic [OUT_W-1:0] dout_o,
  input logic             ovf_o
);
  localparam logic [OUT_W-1:0] MAXC = OUT_SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : {OUT_W{1'b1}};
  localparam logic [OUT_W-1:0] MINC = OUT_SIGNED ? {1'b1, {(OUT_W-1){1'b0}}} : {OUT_W{1'b0}};

  if (OMODE == fxq_pkg::O_SAT) begin : g_sat
    // R3: a flagged word in saturate mode is an end-of-range code
    p_sat_codes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |-> (dout_o == MAXC || dout_o == MINC));
  end

  if (LATENCY > 0) begin : g_seq
    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_i |=> (dout_o == '0 && !ovf_o));

    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!srst_i && !en_i) |=> ($stable(dout_o) && $stable(ovf_o)));

    // R10: flag moves only on an enabled, uncleared edge
    p_ovf_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_o) |-> $past(en_i && !srst_i));
  end
endmodule

bind fxq_cast fxq_cast_chk #(
  .OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED), .OMODE(OMODE), .LATENCY(LATENCY)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .srst_i(srst_i),
  .en_i  (en_i),
  .dout_o(dout_o),
  .ovf_o (ovf_o)
);

// File: tb/sim_fxq_cast.sv
`timescale 1ns/1ps
module sim_fxq_cast;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srst = 1'b0;
  logic en = 1'b1;
  logic [7:0] din = '0;
  logic [5:0] din3 = '0;

  logic [4:0] q0, q1;
  logic [3:0] q2;
  logic [9:0] q3;
  logic v0, v1, v2, v3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // Q4.4 signed in -> 5 bits, 2 frac, signed; symmetric, saturate, 2 stages
  fxq_cast #(.IN_W(8), .IN_F(4), .IN_SIGNED(1'b1), .OUT_W(5), .OUT_F(2), .OUT_SIGNED(1'b1),
             .QMODE(fxq_pkg::Q_SYM), .OMODE(fxq_pkg::O_SAT), .LATENCY(2))
  u0 (.clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .en_i(en), .din_i(din), .dout_o(q0), .ovf_o(v0));

  // same formats; convergent, wrap, 1 stage
  fxq_cast #(.IN_W(8), .IN_F(4), .IN_SIGNED(1'b1), .OUT_W(5), .OUT_F(2), .OUT_SIGNED(1'b1),
             .QMODE(fxq_pkg::Q_CONV), .OMODE(fxq_pkg::O_WRAP), .LATENCY(1))
  u1 (.clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .en_i(en), .din_i(din), .dout_o(q1), .ovf_o(v1));

  // unsigned 4-bit integer out; truncate, saturate, combinational
  fxq_cast #(.IN_W(8), .IN_F(4), .IN_SIGNED(1'b1), .OUT_W(4), .OUT_F(0), .OUT_SIGNED(1'b0),
             .QMODE(fxq_pkg::Q_TRUNC), .OMODE(fxq_pkg::O_SAT), .LATENCY(0))
  u2 (.clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .en_i(en), .din_i(din), .dout_o(q2), .ovf_o(v2));

  // widening: 6 bits 2 frac -> 10 bits 4 frac, signed; 1 stage
  fxq_cast #(.IN_W(6), .IN_F(2), .IN_SIGNED(1'b1), .OUT_W(10), .OUT_F(4), .OUT_SIGNED(1'b1),
             .QMODE(fxq_pkg::Q_TRUNC), .OMODE(fxq_pkg::O_WRAP), .LATENCY(1))
  u3 (.clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .en_i(en), .din_i(din3), .dout_o(q3), .ovf_o(v3));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic settle(input logic [7:0] d, input logic [5:0] d3);
    @(negedge clk);
    din  = d;
    din3 = d3;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R13 u0 data in reset", int'(q0), 0);
    check("R13 u0 flag in reset", int'(v0), 0);
    check("R13 u1 data in reset", int'(q1), 0);
    check("R13 u3 data in reset", int'(q3), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_truncate;
    settle(8'h5F, 6'h00);               // 5.9375
    check("R1 trunc 5.9375", int'(q2), 5);
    check("R1 trunc flag", int'(v2), 0);
    settle(8'h7F, 6'h00);               // 7.9375
    check("R1 trunc 7.9375", int'(q2), 7);
  endtask

  task automatic t_symmetric;
    settle(8'h16, 6'h00);               // 1.375 tie
    check("R2 sym +tie", int'(q0), 5'h06);
    settle(8'hEA, 6'h00);               // -1.375 tie
    check("R2 sym -tie", int'(q0), 5'h1A);
    settle(8'hEF, 6'h00);               // -1.0625
    check("R2 sym below half", int'(q0), 5'h1C);
    check("R2 sym flag", int'(v0), 0);
  endtask

  task automatic t_convergent;
    settle(8'h16, 6'h00);
    check("R4 conv 1.375", int'(q1), 5'h06);
    settle(8'h1A, 6'h00);
    check("R4 conv 1.625", int'(q1), 5'h06);
    settle(8'h1E, 6'h00);
    check("R4 conv 1.875", int'(q1), 5'h08);
    settle(8'hEA, 6'h00);
    check("R4 conv -1.375", int'(q1), 5'h1A);
  endtask

  task automatic t_saturate;
    settle(8'h7F, 6'h00);
    check("R3 sat high", int'(q0), 5'h0F);
    check("R10 sat high flag", int'(v0), 1);
    settle(8'h80, 6'h00);               // -8.0
    check("R3 sat low", int'(q0), 5'h10);
    check("R10 sat low flag", int'(v0), 1);
    settle(8'hFF, 6'h00);               // -0.0625 into unsigned
    check("R12 unsigned neg", int'(q2), 0);
    check("R12 unsigned flag", int'(v2), 1);
    settle(8'h3D, 6'h00);               // 3.8125 fits
    check("R10 in range data", int'(q0), 5'h0F);
    check("R10 in range flag", int'(v0), 0);
  endtask

  task automatic t_wrap;
    settle(8'h50, 6'h00);               // 5.0 -> 20 -> wraps
    check("R5 wrap data", int'(q1), 5'h14);
    check("R10 wrap flag", int'(v1), 1);
  endtask

  task automatic t_round_carry;
    settle(8'h3E, 6'h00);               // 3.875 rounds to 4.0
    check("R6 carry sat", int'(q0), 5'h0F);
    check("R6 carry sat flag", int'(v0), 1);
    check("R6 carry wrap", int'(q1), 5'h10);
    check("R6 carry wrap flag", int'(v1), 1);
  endtask

  task automatic t_widen;
    settle(8'h00, 6'h3B);               // -1.25
    check("R7 widen negative", int'(q3), 10'h3EC);
    check("R7 widen flag", int'(v3), 0);
    settle(8'h00, 6'h17);               // 5.75
    check("R7 widen positive", int'(q3), 10'h05C);
  endtask

  task automatic t_latency;
    settle(8'h3D, 6'h00);               // u0 steady at 0x0F
    @(negedge clk);
    din = 8'h16;
    #1;
    check("R11 comb follows", int'(q2), 1);
    @(posedge clk);
    @(negedge clk);
    check("R11 u0 after 1 edge", int'(q0), 5'h0F);
    check("R11 u1 after 1 edge", int'(q1), 5'h06);
    @(posedge clk);
    @(negedge clk);
    check("R11 u0 after 2 edges", int'(q0), 5'h06);
  endtask

  task automatic t_hold;
    settle(8'h16, 6'h00);
    @(negedge clk);
    en  = 1'b0;
    din = 8'h3D;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 u0 held", int'(q0), 5'h06);
    check("R9 u1 held", int'(q1), 5'h06);
    en = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 u0 resumes", int'(q0), 5'h0F);
  endtask

  task automatic t_sync_clear;
    settle(8'h7F, 6'h17);
    @(negedge clk);
    en   = 1'b0;
    srst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 u0 cleared", int'(q0), 0);
    check("R8 u0 flag cleared", int'(v0), 0);
    check("R8 u1 cleared", int'(q1), 0);
    check("R8 u3 cleared", int'(q3), 0);
    srst = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 stays zero while disabled", int'(q0), 0);
    en = 1'b1;
  endtask

  initial begin
    t_reset();
    t_truncate();
    t_symmetric();
    t_convergent();
    t_saturate();
    t_wrap();
    t_round_carry();
    t_widen();
    t_latency();
    t_hold();
    t_sync_clear();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule